// File: doc/BRIEF.md
# Cascadable Bidirectional Pixel Sampling Register

This block sits at the input of a display column driver. On every rising edge of the shift clock it can take in one 18-bit pixel word. The word holds three 6-bit gray codes. A one-hot token moves along a chain of 103 stages, and each stage owns three adjacent columns of a line buffer that holds up to 309 dot codes. The stage that holds the token captures the word. A start pulse arms the token. A direction input sets whether the columns fill upward from column 1 or downward from the last active column.

A width select sets the active line to 300 columns (100 stages) or 309 columns (103 stages). When the token writes its final stage, the block sends a one-clock start pulse to the next driver in the cascade. The two start pins swap between input and output roles with the direction input. Each pin is modelled as an input, an output value and an output enable.

Top module: `pixel_sample_chain`

## Requirements
- R1: While `rst_n` is low, and after its release until the first start, `line_buf` reads all zeros, both start output values are 0, and no token is armed.
- R2: Within a word, bits [5:0] carry the dot of the lowest column of the written stage, bits [11:6] the middle column and bits [17:12] the highest. Bit 0 of each dot is its LSB. Column c (1-based) sits at `line_buf[6*(c-1) +: 6]`.
- R3: With `dir_fwd` high, the k-th rising edge after the edge on which a start is taken writes stage k, which covers columns 3k-2 to 3k.
- R4: With `dir_fwd` low, the k-th edge after the start writes stage L-k+1, where L is 103 in wide mode and 100 in narrow mode.
- R5: With `narrow_mode` high, the cascade start output goes high at the 100th edge after the start and stays high for exactly one clock period.
- R6: With `narrow_mode` low, the cascade start output goes high at the 103rd edge after the start and stays high for exactly one clock period.
- R7: With `dir_fwd` high, the start input is `start_r_i`, `start_l_oe`=1 and `start_r_oe`=0, and the cascade pulse appears on `start_l_o`. With `dir_fwd` low the roles swap. The value of the pin that is not driving is always 0.
- R8: After the last active stage has been written, further words leave `line_buf` unchanged until a new start is taken.
- R9: In narrow mode, columns 301 to 309 keep their previous contents.
- R10: A start taken while a sweep is in progress restarts the sweep from the first stage. The edge that takes a start writes no data.
- R11: A pulse on the start pin that is in its output role is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; data and start are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dir_fwd | input | 1 | 1: fill columns upward, start enters on the right pin; 0: fill downward, start enters on the left pin |
| narrow_mode | input | 1 | 1: 300 active columns; 0: 309 active columns |
| pix_word | input | 18 | Three 6-bit dot codes, lowest column in bits [5:0] |
| start_r_i | input | 1 | Right start pin, input value |
| start_r_o | output | 1 | Right start pin, driven value |
| start_r_oe | output | 1 | Right start pin, output enable |
| start_l_i | input | 1 | Left start pin, input value |
| start_l_o | output | 1 | Left start pin, driven value |
| start_l_oe | output | 1 | Left start pin, output enable |
| line_buf | output | 1854 | Line buffer, 309 dot codes of 6 bits, column 1 at the LSBs |

## Verification
The edge that takes a start pulse only arms the token. The k-th following edge writes its stage, so the change in `line_buf` is visible right after that edge. The cascade pulse is registered: it is high in the period between edge N and edge N+1, where N is 100 or 103. The bench drives all inputs at the falling edge and steps its reference model at the next rising edge using those same inputs. It then compares the buffer, the pin values and the output enables at the following falling edge, so each result is checked in the cycle it is due. Direction and width change only while the token is idle.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned DOT_W          = 6;
  localparam int unsigned DOTS_PER_STAGE = 3;
  localparam int unsigned WORD_W         = DOT_W * DOTS_PER_STAGE;
endpackage

// File: rtl/psr_token_chain.sv
// One-hot token chain: arms on a start, walks up or down, stops after the
// last active stage.
module psr_token_chain #(
  parameter int unsigned STAGES        = 103,
  parameter int unsigned NARROW_STAGES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_fwd,
  input  logic              narrow,
  input  logic              start,
  output logic [STAGES-1:0] tok_q,
  output logic [STAGES-1:0] we,
  output logic              end_hit
);

  logic [STAGES-1:0] seed;
  logic [STAGES-1:0] keep;
  logic [STAGES-1:0] tok_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage_ctl
    localparam bit IS_FIRST    = (i == 0);
    localparam bit IS_WIDE_END = (i == STAGES - 1);
    localparam bit IS_NAR_END  = (i == NARROW_STAGES - 1);
    localparam bit IN_NARROW   = (i < NARROW_STAGES);
    assign seed[i] = dir_fwd ? IS_FIRST : (narrow ? IS_NAR_END : IS_WIDE_END);
    assign keep[i] = narrow ? IN_NARROW : 1'b1;
  end

  // next state
  always_comb begin
    if (start) begin
      tok_d = seed;
    end else if (dir_fwd) begin
      tok_d = (tok_q << 1) & keep;
    end else begin
      tok_d = tok_q >> 1;
    end
  end

  // a start edge arms only; it never writes
  always_comb begin
    we      = start ? '0 : tok_q;
    end_hit = 1'b0;
    if (!start) begin
      if (dir_fwd) begin
        end_hit = narrow ? tok_q[NARROW_STAGES-1] : tok_q[STAGES-1];
      end else begin
        end_hit = tok_q[0];
      end
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q <= '0;
    end else begin
      tok_q <= tok_d;
    end
  end

endmodule

// File: rtl/psr_stage_reg.sv
// Three-dot capture register for one stage of the line buffer.
module psr_stage_reg #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (we) begin
      q_d = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/psr_start_io.sv
// Start pin role control and registered cascade pulse.
module psr_start_io (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_fwd,
  input  logic end_hit,
  input  logic start_r_i,
  input  logic start_l_i,
  output logic start_sel,
  output logic casc_q,
  output logic start_r_o,
  output logic start_r_oe,
  output logic start_l_o,
  output logic start_l_oe
);

  logic casc_d;

  assign start_sel = dir_fwd ? start_r_i : start_l_i;
  assign casc_d    = end_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      casc_q <= 1'b0;
    end else begin
      casc_q <= casc_d;
    end
  end

  always_comb begin
    start_l_oe = dir_fwd;
    start_r_oe = !dir_fwd;
    start_l_o  = dir_fwd  ? casc_q : 1'b0;
    start_r_o  = !dir_fwd ? casc_q : 1'b0;
  end

endmodule

// File: rtl/pixel_sample_chain.sv
module pixel_sample_chain
  import psr_pkg::*;
#(
  parameter int unsigned STAGES        = 103,
  parameter int unsigned NARROW_STAGES = 100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dir_fwd,
  input  logic                       narrow_mode,
  input  logic [WORD_W-1:0]          pix_word,
  input  logic                       start_r_i,
  output logic                       start_r_o,
  output logic                       start_r_oe,
  input  logic                       start_l_i,
  output logic                       start_l_o,
  output logic                       start_l_oe,
  output logic [STAGES*WORD_W-1:0]   line_buf
);

  logic              start_sel;
  logic              casc_q;
  logic              end_hit;
  logic [STAGES-1:0] tok_q;
  logic [STAGES-1:0] we;

  psr_start_io u_io (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir_fwd    (dir_fwd),
    .end_hit    (end_hit),
    .start_r_i  (start_r_i),
    .start_l_i  (start_l_i),
    .start_sel  (start_sel),
    .casc_q     (casc_q),
    .start_r_o  (start_r_o),
    .start_r_oe (start_r_oe),
    .start_l_o  (start_l_o),
    .start_l_oe (start_l_oe)
  );

  psr_token_chain #(
    .STAGES        (STAGES),
    .NARROW_STAGES (NARROW_STAGES)
  ) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .dir_fwd (dir_fwd),
    .narrow  (narrow_mode),
    .start   (start_sel),
    .tok_q   (tok_q),
    .we      (we),
    .end_hit (end_hit)
  );

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    psr_stage_reg #(.W(WORD_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we[g]),
      .d     (pix_word),
      .q     (line_buf[g*WORD_W +: WORD_W])
    );
  end

endmodule

// File: rtl/psr_chain_checker.sv
module psr_chain_checker #(
  parameter int unsigned STAGES        = 103,
  parameter int unsigned NARROW_STAGES = 100,
  parameter int unsigned WORD_W        = 18
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     narrow_mode,
  input logic                     casc_q,
  input logic [STAGES-1:0]        tok_q,
  input logic                     start_r_o,
  input logic                     start_r_oe,
  input logic                     start_l_o,
  input logic                     start_l_oe,
  input logic [STAGES*WORD_W-1:0] line_buf
);

  localparam int unsigned TAIL_LO = NARROW_STAGES * WORD_W;
  localparam int unsigned TAIL_HI = STAGES * WORD_W - 1;

  // R5 / R6: cascade pulse lasts one period
  p_pulse_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    casc_q |=> !casc_q);

  // R3 / R4: at most one stage holds the token
  p_token_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tok_q));

  // R7: exactly one pin drives, the other stays low
  p_pin_roles_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_r_oe != start_l_oe) && (start_r_oe || !start_r_o) && (start_l_oe || !start_l_o));

  // R8: once the cascade pulse is out, the chain is idle
  p_idle_after_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    casc_q |-> (tok_q == '0));

  // R9: narrow mode never touches the upper stages
  p_tail_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_mode && $past(narrow_mode)) |-> $stable(line_buf[TAIL_HI:TAIL_LO]));

endmodule

bind pixel_sample_chain psr_chain_checker #(
  .STAGES        (STAGES),
  .NARROW_STAGES (NARROW_STAGES),
  .WORD_W        (psr_pkg::WORD_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .narrow_mode (narrow_mode),
  .casc_q      (casc_q),
  .tok_q       (tok_q),
  .start_r_o   (start_r_o),
  .start_r_oe  (start_r_oe),
  .start_l_o   (start_l_o),
  .start_l_oe  (start_l_oe),
  .line_buf    (line_buf)
);

// File: tb/test_pixel_sample_chain.sv
`timescale 1ns/1ps
module test_pixel_sample_chain;
  localparam int STG = 103;
  localparam int NAR = 100;
  localparam int WW  = 18;
  localparam int BW  = STG * WW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dir_fwd;
  logic          narrow_mode;
  logic [WW-1:0] pix_word;
  logic          start_r_i, start_l_i;
  logic          start_r_o, start_r_oe, start_l_o, start_l_oe;
  logic [BW-1:0] line_buf;

  always #4 clk = ~clk;

  pixel_sample_chain i_pixel_sample_chain (
    .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd), .narrow_mode(narrow_mode),
    .pix_word(pix_word), .start_r_i(start_r_i), .start_r_o(start_r_o),
    .start_r_oe(start_r_oe), .start_l_i(start_l_i), .start_l_o(start_l_o),
    .start_l_oe(start_l_oe), .line_buf(line_buf)
  );

  int total = 0;
  int bad   = 0;

  // reference model state
  logic [BW-1:0] exp_buf;
  bit            m_active;
  int            m_cnt;
  bit            exp_cas;

  function automatic int last_stage(input bit nar);
    return nar ? NAR : STG;
  endfunction

  task automatic model_edge(input bit dir, input bit nar, input bit sr,
                            input bit sl, input logic [WW-1:0] w);
    bit st;
    int k;
    int stage;
    int last;
    st   = dir ? sr : sl;
    last = last_stage(nar);
    if (st) begin
      m_active = 1'b1;
      m_cnt    = 0;
      exp_cas  = 1'b0;
    end else if (m_active) begin
      k     = m_cnt + 1;
      stage = dir ? k : (last - k + 1);
      for (int j = 0; j < 3; j++)
        exp_buf[((stage - 1) * 3 + j) * 6 +: 6] = w[j * 6 +: 6];
      m_cnt   = k;
      exp_cas = (k == last);
      if (k == last) m_active = 1'b0;
    end else begin
      exp_cas = 1'b0;
    end
  endtask

  task automatic check_buf(input string tag);
    int col;
    total++;
    if (line_buf !== exp_buf) begin
      col = 0;
      for (int c = STG * 3 - 1; c >= 0; c--)
        if (line_buf[c * 6 +: 6] !== exp_buf[c * 6 +: 6]) col = c;
      bad++;
      $display("FAIL %s column %0d actual=%h expected=%h", tag, col + 1,
               line_buf[col * 6 +: 6], exp_buf[col * 6 +: 6]);
    end
  endtask

  task automatic check_pins(input string tag);
    logic [3:0] act, expv;
    act  = {start_l_oe, start_l_o, start_r_oe, start_r_o};
    expv = {dir_fwd, dir_fwd & exp_cas, ~dir_fwd, ~dir_fwd & exp_cas};
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s pins {l_oe,l_o,r_oe,r_o} actual=%b expected=%b", tag, act, expv);
    end
  endtask

  // one clock: drive at falling edge, model at rising, check at next falling
  task automatic cyc(input bit dir, input bit nar, input bit sr, input bit sl,
                     input logic [WW-1:0] w, input string dtag, input string ptag);
    dir_fwd     = dir;
    narrow_mode = nar;
    start_r_i   = sr;
    start_l_i   = sl;
    pix_word    = w;
    @(posedge clk);
    model_edge(dir, nar, sr, sl, w);
    @(negedge clk);
    check_buf(dtag);
    check_pins(ptag);
  endtask

  task automatic run_line(input bit dir, input bit nar, input int extra,
                          input bit noise, input string dtag, input string ptag);
    int n;
    n = last_stage(nar);
    // start edge: the word offered here must not be written (R10)
    cyc(dir, nar, dir, !dir, WW'($urandom()), "R10", ptag);
    for (int k = 0; k < n; k++)
      cyc(dir, nar, noise && !dir && ($urandom() % 4 == 0),
          noise && dir && ($urandom() % 4 == 0), WW'($urandom()), dtag, ptag);
    for (int e = 0; e < extra; e++)
      cyc(dir, nar, 1'b0, 1'b0, WW'($urandom()), "R8", "R7");
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R1..all actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [WW-1:0] w0;
    void'($urandom(32'h5eed_0013));
    rst_n = 1'b0; dir_fwd = 1'b0; narrow_mode = 1'b0;
    start_r_i = 1'b0; start_l_i = 1'b0; pix_word = '0;
    exp_buf = '0; m_active = 1'b0; m_cnt = 0; exp_cas = 1'b0;
    repeat (3) @(negedge clk);
    check_buf("R1");
    check_pins("R1");
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 18'h3ffff, "R1", "R1");

    // R2: explicit packing of the first word in forward wide mode
    w0 = {6'h2a, 6'h01, 6'h3e};
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 18'h15555, "R10", "R7");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, w0, "R3", "R6");
    total++;
    if (line_buf[5:0] !== 6'h3e || line_buf[11:6] !== 6'h01 || line_buf[17:12] !== 6'h2a) begin
      bad++;
      $display("FAIL R2 columns1-3 actual=%h expected=%h", line_buf[17:0], w0);
    end
    for (int k = 1; k < STG; k++)
      cyc(1'b1, 1'b0, 1'b0, 1'b0, WW'($urandom()), "R3", "R6");
    for (int e = 0; e < 6; e++)
      cyc(1'b1, 1'b0, 1'b0, 1'b0, WW'($urandom()), "R8", "R7");

    run_line(1'b0, 1'b0, 4, 1'b0, "R4", "R6");   // reverse wide
    run_line(1'b1, 1'b1, 4, 1'b0, "R9", "R5");   // forward narrow
    run_line(1'b0, 1'b1, 4, 1'b0, "R4", "R5");   // reverse narrow

    // R11: pulse on the output-role pin in each direction
    cyc(1'b1, 1'b0, 1'b0, 1'b1, WW'($urandom()), "R11", "R11");
    for (int e = 0; e < 5; e++)
      cyc(1'b1, 1'b0, 1'b0, 1'b0, WW'($urandom()), "R11", "R11");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, WW'($urandom()), "R11", "R11");
    for (int e = 0; e < 5; e++)
      cyc(1'b0, 1'b0, 1'b0, 1'b0, WW'($urandom()), "R11", "R11");

    // R10: restart in the middle of a sweep
    cyc(1'b1, 1'b0, 1'b1, 1'b0, WW'($urandom()), "R10", "R7");
    for (int k = 0; k < 20; k++)
      cyc(1'b1, 1'b0, 1'b0, 1'b0, WW'($urandom()), "R3", "R7");
    cyc(1'b1, 1'b0, 1'b1, 1'b0, WW'($urandom()), "R10", "R10");
    for (int k = 0; k < STG + 3; k++)
      cyc(1'b1, 1'b0, 1'b0, 1'b0, WW'($urandom()), "R10", "R6");

    // random lines with noise on the inactive pin
    for (int l = 0; l < 12; l++)
      run_line(1'($urandom()), 1'($urandom()), int'($urandom() % 6), 1'b1, "R3", "R7");

    summary();
    $finish;
  end
endmodule